// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, for one eight-level interrupt controller, which pending request should go to the processor next and which in-service level a non-specific end-of-interrupt should retire. It is purely combinational. The surrounding controller holds the request, in-service and mask bytes, a lowest-priority pointer and two mode flags. It presents them on every cycle and samples both answers in the same cycle.

Priority is circular. The level just after the lowest-priority pointer ranks highest, and the ranking wraps through all eight levels. For the request answer, an in-service level shuts out every request of equal or lower rank. Two modes relax this. The special mask mode removes the in-service state from the request search entirely. The special nesting mode stops the cascade level's in-service bit from blocking. In the special mask mode, the in-service answer also passes over levels that are masked.

Top module: `rot_prio_resolver`

## Requirements
- R1: Ranking starts at level (lowPrio + 1) mod 8 and proceeds upward with wrap-around. When two or more eligible requests are present and nothing blocks, pendLevel is the eligible level reached first in that order.
- R2: With lowPrio = 7, level 0 ranks highest and level 7 lowest.
- R3: A level is eligible for pendLevel only when its reqBits bit is 1 and its maskBits bit is 0. A masked request is never reported.
- R4: When the special modes are off, an in-service level of equal or higher rank than every eligible request makes pendValid 0. This includes an in-service bit on the requesting level itself.
- R5: An in-service level that ranks below an eligible request does not block that request.
- R6: When specialMask is 1, isrBits has no effect on pendValid or pendLevel.
- R7: When specialNest is 1, the in-service bit of the cascade level (level 2) does not block the request search. In-service bits on other levels still block.
- R8: svcLevel is the first level in rank order whose isrBits bit is 1.
- R9: When specialMask is 1, the in-service search skips levels whose maskBits bit is 1. When specialMask is 0, the mask has no effect on that search.
- R10: When no level qualifies, the matching valid output is 0 and its level output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqBits | input | 8 | Pending request bit per level |
| isrBits | input | 8 | In-service bit per level |
| maskBits | input | 8 | Mask bit per level, 1 = masked |
| lowPrio | input | 3 | Level that currently ranks lowest |
| specialMask | input | 1 | Special mask mode enable |
| specialNest | input | 1 | Special nesting mode enable (cascade level never blocks) |
| pendValid | output | 1 | An eligible, unblocked request exists |
| pendLevel | output | 3 | Level of that request, 0 when none |
| svcValid | output | 1 | A qualifying in-service level exists |
| svcLevel | output | 3 | Level for a non-specific end-of-interrupt, 0 when none |

## Verification
Both searches are answered in the same cycle from the same in-service byte. One stimulus can therefore leave the pending answer blocked by an in-service level while that same level is the service answer. The bench provokes this by placing an in-service bit above, at and below a request under several pointer values. In each case it judges both output pairs together in one sample. A separate sweep places two requests at every pair of levels under every pointer value. It checks that the level closer to the rotation point is chosen.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int LEVELS = 8;

  // Strobes handed from the mode control to the scanning datapath.
  typedef struct packed {
    logic [LEVELS-1:0] eligible;  // request present and unmasked
    logic [LEVELS-1:0] blocking;  // in-service levels that stop the request scan
    logic [LEVELS-1:0] svcCand;   // in-service levels the service scan may return
  } rpr_strobes_t;
endpackage

// File: rtl/rpr_first_set.sv
module rpr_first_set #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vecIn,
  output logic         found,
  output logic [W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vecIn[i]) pos = W'(i);
    end
    found = |vecIn;
  end

  always_comb begin
    if (found) assert_found_bit_set_R8: assert (vecIn[pos]);
  end
endmodule

// File: rtl/rpr_ctrl.sv
module rpr_ctrl
  import rpr_pkg::*;
#(
  parameter int NUM_LEVELS    = LEVELS,
  parameter int CASCADE_LEVEL = 2
) (
  input  logic [NUM_LEVELS-1:0] reqBits,
  input  logic [NUM_LEVELS-1:0] isrBits,
  input  logic [NUM_LEVELS-1:0] maskBits,
  input  logic                  specialMask,
  input  logic                  specialNest,
  output rpr_strobes_t          strobes
);
  localparam logic [NUM_LEVELS-1:0] CASCADE_BIT = NUM_LEVELS'(1) << CASCADE_LEVEL;

  logic [NUM_LEVELS-1:0] nestExempt;

  always_comb begin
    nestExempt        = specialNest ? CASCADE_BIT : '0;
    strobes.eligible  = reqBits & ~maskBits;
    strobes.blocking  = specialMask ? '0 : (isrBits & ~nestExempt);
    strobes.svcCand   = isrBits & ~(specialMask ? maskBits : '0);
  end
endmodule

// File: rtl/rpr_dpath.sv
module rpr_dpath
  import rpr_pkg::*;
#(
  parameter int NUM_LEVELS = LEVELS,
  parameter int IDX_W      = $clog2(NUM_LEVELS)
) (
  input  rpr_strobes_t     strobes,
  input  logic [IDX_W-1:0] lowPrio,
  output logic             pendValid,
  output logic [IDX_W-1:0] pendLevel,
  output logic             svcValid,
  output logic [IDX_W-1:0] svcLevel
);
  logic [IDX_W-1:0]      startLevel;
  logic [NUM_LEVELS-1:0] rotStop, rotBlock, rotSvc;
  logic                  stopFound, svcFound;
  logic [IDX_W-1:0]      stopPos, svcPos;

  assign startLevel = lowPrio + IDX_W'(1);

  // Rank k maps to level (startLevel + k) mod NUM_LEVELS.
  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_rot
    localparam logic [IDX_W-1:0] OFS = IDX_W'(k);
    logic [IDX_W-1:0] lvl;
    assign lvl         = startLevel + OFS;
    assign rotBlock[k] = strobes.blocking[lvl];
    assign rotStop[k]  = strobes.blocking[lvl] | strobes.eligible[lvl];
    assign rotSvc[k]   = strobes.svcCand[lvl];
  end

  rpr_first_set #(.N(NUM_LEVELS), .W(IDX_W)) u_stopScan (
    .vecIn(rotStop), .found(stopFound), .pos(stopPos)
  );

  rpr_first_set #(.N(NUM_LEVELS), .W(IDX_W)) u_svcScan (
    .vecIn(rotSvc), .found(svcFound), .pos(svcPos)
  );

  always_comb begin
    pendValid = stopFound && !rotBlock[stopPos];
    pendLevel = pendValid ? startLevel + stopPos : '0;
    svcValid  = svcFound;
    svcLevel  = svcFound ? startLevel + svcPos : '0;
  end

  always_comb begin
    if (pendValid) assert_pend_eligible_R3: assert (strobes.eligible[pendLevel]);
    else           assert_pend_idle_zero_R10: assert (pendLevel == '0);
    if (svcValid)  assert_svc_candidate_R8: assert (strobes.svcCand[svcLevel]);
    else           assert_svc_idle_zero_R10: assert (svcLevel == '0);
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int NUM_LEVELS    = LEVELS,
  parameter int CASCADE_LEVEL = 2,
  parameter int IDX_W         = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] reqBits,
  input  logic [NUM_LEVELS-1:0] isrBits,
  input  logic [NUM_LEVELS-1:0] maskBits,
  input  logic [IDX_W-1:0]      lowPrio,
  input  logic                  specialMask,
  input  logic                  specialNest,
  output logic                  pendValid,
  output logic [IDX_W-1:0]      pendLevel,
  output logic                  svcValid,
  output logic [IDX_W-1:0]      svcLevel
);
  rpr_strobes_t strobes;

  rpr_ctrl #(.NUM_LEVELS(NUM_LEVELS), .CASCADE_LEVEL(CASCADE_LEVEL)) u_ctrl (
    .reqBits(reqBits), .isrBits(isrBits), .maskBits(maskBits),
    .specialMask(specialMask), .specialNest(specialNest), .strobes(strobes)
  );

  rpr_dpath #(.NUM_LEVELS(NUM_LEVELS), .IDX_W(IDX_W)) u_dpath (
    .strobes(strobes), .lowPrio(lowPrio),
    .pendValid(pendValid), .pendLevel(pendLevel),
    .svcValid(svcValid), .svcLevel(svcLevel)
  );

  always_comb begin
    if (pendValid) begin
      assert_pend_unmasked_R3: assert (reqBits[pendLevel] && !maskBits[pendLevel]);
      if (!specialMask && isrBits[pendLevel])
        assert_pend_not_self_blocked_R4: assert (specialNest && pendLevel == IDX_W'(CASCADE_LEVEL));
    end
    if (svcValid) begin
      assert_svc_in_service_R8: assert (isrBits[svcLevel]);
      if (specialMask) assert_svc_skip_masked_R9: assert (!maskBits[svcLevel]);
    end
  end
endmodule

// File: tb/rot_prio_resolver_bench.sv
module rot_prio_resolver_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] reqBits, isrBits, maskBits;
  logic [2:0] lowPrio;
  logic specialMask, specialNest;
  logic pendValid, svcValid;
  logic [2:0] pendLevel, svcLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rot_prio_resolver u_rot_prio_resolver (
    .reqBits(reqBits), .isrBits(isrBits), .maskBits(maskBits), .lowPrio(lowPrio),
    .specialMask(specialMask), .specialNest(specialNest),
    .pendValid(pendValid), .pendLevel(pendLevel),
    .svcValid(svcValid), .svcLevel(svcLevel)
  );

  task automatic drive(input logic [7:0] r, input logic [7:0] s, input logic [7:0] m,
                       input logic [2:0] lp, input logic smm, input logic sfn);
    @(posedge clk);
    reqBits = r; isrBits = s; maskBits = m; lowPrio = lp;
    specialMask = smm; specialNest = sfn;
    @(negedge clk);
  endtask

  task automatic chkPend(input string req, input logic v, input logic [2:0] l);
    checks++;
    if (pendValid !== v || pendLevel !== l) begin
      fails++;
      $display("FAIL %s pend: got v=%0b l=%0d exp v=%0b l=%0d", req, pendValid, pendLevel, v, l);
    end
  endtask

  task automatic chkSvc(input string req, input logic v, input logic [2:0] l);
    checks++;
    if (svcValid !== v || svcLevel !== l) begin
      fails++;
      $display("FAIL %s svc: got v=%0b l=%0d exp v=%0b l=%0d", req, svcValid, svcLevel, v, l);
    end
  endtask

  task automatic t_idle();  // R10
    drive(8'h00, 8'h00, 8'h00, 3'd7, 0, 0);
    chkPend("R10", 0, 0); chkSvc("R10", 0, 0);
  endtask

  task automatic t_default_order();  // R2
    drive(8'b0010_1000, 8'h00, 8'h00, 3'd7, 0, 0); chkPend("R2", 1, 3);
    drive(8'b1000_0001, 8'h00, 8'h00, 3'd7, 0, 0); chkPend("R2", 1, 0);
  endtask

  task automatic t_rotation();  // R1
    drive(8'b0010_1000, 8'h00, 8'h00, 3'd3, 0, 0); chkPend("R1", 1, 5);
    drive(8'b0010_1000, 8'h00, 8'h00, 3'd5, 0, 0); chkPend("R1", 1, 3);
  endtask

  task automatic t_mask();  // R3, R10
    drive(8'b0010_1000, 8'h00, 8'b0000_1000, 3'd7, 0, 0); chkPend("R3", 1, 5);
    drive(8'b0010_1000, 8'h00, 8'b0010_1000, 3'd7, 0, 0); chkPend("R10", 0, 0);
  endtask

  task automatic t_block_and_service();  // R4, R5, R8 in one sample
    drive(8'b0000_1000, 8'b0000_0010, 8'h00, 3'd7, 0, 0);
    chkPend("R4", 0, 0); chkSvc("R8", 1, 1);
    drive(8'b0000_1000, 8'b0000_1000, 8'h00, 3'd7, 0, 0);
    chkPend("R4", 0, 0); chkSvc("R8", 1, 3);
    drive(8'b0000_1000, 8'b0010_0000, 8'h00, 3'd7, 0, 0);
    chkPend("R5", 1, 3); chkSvc("R8", 1, 5);
    drive(8'b0000_1000, 8'b0000_0010, 8'h00, 3'd1, 0, 0);  // level 1 now lowest
    chkPend("R5", 1, 3); chkSvc("R8", 1, 1);
  endtask

  task automatic t_special_mask();  // R6
    drive(8'b0000_1000, 8'b0000_0010, 8'h00, 3'd7, 1, 0); chkPend("R6", 1, 3);
    drive(8'b0000_1000, 8'b0000_1000, 8'h00, 3'd7, 1, 0); chkPend("R6", 1, 3);
  endtask

  task automatic t_special_nest();  // R7
    drive(8'b0001_0000, 8'b0000_0100, 8'h00, 3'd7, 0, 1); chkPend("R7", 1, 4);
    drive(8'b0001_0000, 8'b0000_0100, 8'h00, 3'd7, 0, 0); chkPend("R7", 0, 0);
    drive(8'b0001_0000, 8'b0000_0010, 8'h00, 3'd7, 0, 1); chkPend("R7", 0, 0);
  endtask

  task automatic t_service_order();  // R8
    drive(8'h00, 8'b1010_0100, 8'h00, 3'd7, 0, 0); chkSvc("R8", 1, 2);
    drive(8'h00, 8'b1010_0100, 8'h00, 3'd2, 0, 0); chkSvc("R8", 1, 5);
    drive(8'h00, 8'b1010_0100, 8'h00, 3'd6, 0, 0); chkSvc("R8", 1, 7);
  endtask

  task automatic t_service_mask();  // R9, R10
    drive(8'h00, 8'b0010_0100, 8'b0000_0100, 3'd7, 1, 0); chkSvc("R9", 1, 5);
    drive(8'h00, 8'b0010_0100, 8'b0000_0100, 3'd7, 0, 0); chkSvc("R9", 1, 2);
    drive(8'h00, 8'b0010_0100, 8'b0010_0100, 3'd7, 1, 0); chkSvc("R10", 0, 0);
  endtask

  task automatic t_pair_sweep();  // R1
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          if (a != b) begin
            int da = (a - p - 1) & 7;
            int db = (b - p - 1) & 7;
            logic [2:0] win = (da < db) ? 3'(a) : 3'(b);
            drive((8'd1 << a) | (8'd1 << b), 8'h00, 8'h00, 3'(p), 0, 0);
            chkPend("R1", 1, win);
          end
        end
      end
    end
  endtask

  initial begin
    reqBits = '0; isrBits = '0; maskBits = '0; lowPrio = 3'd7;
    specialMask = 0; specialNest = 0;
    t_idle();
    t_default_order();
    t_rotation();
    t_mask();
    t_block_and_service();
    t_special_mask();
    t_special_nest();
    t_service_order();
    t_service_mask();
    t_pair_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule